// File: doc/BRIEF.md
# Delayed Branch Decode and Slot Annul Unit

This unit sits in the decode stage of a five-stage pipeline. It recognises three control-transfer formats in the instruction word:

- a call that carries an absolute word target;
- a conditional branch that carries a PC-relative word offset, a condition selector and an annul bit;
- a return that takes its target from a register.

For a conditional branch the unit tests the selected condition against the ALU flags. For any transfer that goes ahead it raises a redirect together with the new fetch address.

Every transfer is delayed by exactly one slot. Because the decision is made in decode, the instruction being fetched at that moment is the delay slot. It normally executes whatever the branch outcome. A conditional branch with its annul bit set makes the slot conditional on the branch being taken: when such a branch falls through, the unit raises a kill so that the fetched slot never enters decode.

Calls and returns have no annul option. If the flags are not yet valid when a flag-dependent branch is decoded, the unit holds decode for exactly one cycle. It then decides on the flags present in the following cycle.

Top module: `br_decode_unit`

## Requirements
- R1: A valid word with bits [31:30] = 01 is a call. It raises `redirect_o` with `target_o` = {bits[29:0], 00}, never raises `slot_kill_o`, and `target_o` is 0 whenever `redirect_o` is low.
- R2: A conditional branch has bits [31:24] = 8'h8A, condition in [23:20], annul flag in [19] and a signed offset in [18:0]. Its target is `pc_i` plus the sign-extended offset shifted left by two.
- R3: The flags are packed as `flags_i` = {N, Z, C, V}. Condition bit 3 inverts the test chosen by bits [2:0]: 000 false, 001 Z, 010 Z|(N^V), 011 N^V, 100 C|Z, 101 C, 110 N, 111 V. A branch whose condition holds raises `redirect_o`.
- R4: A conditional branch whose condition fails gives no redirect. With annul = 0 it gives no kill.
- R5: A conditional branch with annul = 1 raises `slot_kill_o` exactly when it is not taken. No other case raises the kill.
- R6: A return has bits [31:24] = 8'h8C and register addresses in [23:19] and [18:14], which appear on `rs_a_o` and `rs_b_o`. It redirects to `ret_val_i`. For any other word both address outputs are 0.
- R7: A branch with condition bits [2:0] != 000 that is decoded while `flags_vld_i` is low raises `stall_o` for one cycle, with no redirect and no kill. In the next cycle it decides on `flags_i` without regard to `flags_vld_i`.
- R8: Conditions 0000 (never) and 1000 (always) are decided at once, even when `flags_vld_i` is low.
- R9: When `instr_vld_i` is low, or the word matches no transfer format, `redirect_o`, `slot_kill_o` and `stall_o` stay low.
- R10: While `rst` is high all outputs are inactive, and reset clears a pending flag wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word in decode |
| instr_vld_i | input | 1 | Decode word is valid |
| pc_i | input | 32 | Address of the decode word |
| flags_i | input | 4 | ALU flags {N, Z, C, V} |
| flags_vld_i | input | 1 | Flags reflect all older instructions |
| ret_val_i | input | 32 | Value read from the return register |
| redirect_o | output | 1 | Fetch must continue at `target_o` after the slot |
| target_o | output | 32 | Redirect address |
| slot_kill_o | output | 1 | Drop the fetched delay slot |
| stall_o | output | 1 | Hold decode one cycle for flags |
| rs_a_o | output | 5 | First register read address |
| rs_b_o | output | 5 | Second register read address |

## Verification
Two functions can fall in the same cycle: the end of the one-cycle flag wait and the annul kill. The bench decodes an annulled branch while flags are invalid, checks that the first cycle shows only the stall, and then checks that the following cycle raises the kill, with no redirect, on the newly presented flags. A second wait case resolves to taken, and a reset applied in the middle of a wait must bring the stall back instead of letting a stale decision through.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
    localparam int XLEN    = 32;
    localparam int RADDR_W = 5;
    localparam int OFF_W   = 19;
    localparam int COND_W  = 4;
    localparam int IMM_W   = XLEN - 2;
    localparam int EXT_W   = XLEN - OFF_W - 2;

    localparam logic [1:0] OP_CALL = 2'b01;
    localparam logic [7:0] OP_BCC  = 8'h8A;
    localparam logic [7:0] OP_RET  = 8'h8C;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_CALL = 2'd1,
        K_BCC  = 2'd2,
        K_RET  = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        xfer_kind_e          kind;
        logic [COND_W-1:0]   cond;
        logic                annul;
        logic [OFF_W-1:0]    off;
        logic [IMM_W-1:0]    imm;
        logic [RADDR_W-1:0]  ra;
        logic [RADDR_W-1:0]  rb;
    } dec_t;

    function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] pc,
                                                   input logic [OFF_W-1:0] off);
        return pc + {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    endfunction
endpackage

// File: rtl/bdu_field_decode.sv
module bdu_field_decode
    import bdu_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic            vld,
    output dec_t            dec
);
    always_comb begin
        dec       = '0;
        dec.kind  = K_NONE;
        dec.cond  = instr[23:20];
        dec.annul = instr[19];
        dec.off   = instr[OFF_W-1:0];
        dec.imm   = instr[IMM_W-1:0];
        if (vld) begin
            if (instr[31:30] == OP_CALL) begin
                dec.kind = K_CALL;
            end else if (instr[31:24] == OP_BCC) begin
                dec.kind = K_BCC;
            end else if (instr[31:24] == OP_RET) begin
                dec.kind = K_RET;
                dec.ra   = instr[23:19];
                dec.rb   = instr[18:14];
            end
        end
    end
endmodule

// File: rtl/bdu_cond_eval.sv
module bdu_cond_eval
    import bdu_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flags,
    output logic              holds,
    output logic              needs_flags
);
    logic base;

    always_comb begin
        unique case (cond[2:0])
            3'd0: base = 1'b0;
            3'd1: base = flags.z;
            3'd2: base = flags.z | (flags.n ^ flags.v);
            3'd3: base = flags.n ^ flags.v;
            3'd4: base = flags.c | flags.z;
            3'd5: base = flags.c;
            3'd6: base = flags.n;
            default: base = flags.v;
        endcase
    end

    assign holds       = base ^ cond[3];
    assign needs_flags = (cond[2:0] != 3'd0);
endmodule

// File: rtl/bdu_slot_ctrl.sv
module bdu_slot_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic is_bcc,
    input  logic needs_flags,
    input  logic flags_vld,
    input  logic holds,
    input  logic annul,
    output logic stall,
    output logic taken,
    output logic kill
);
    logic wait_q;
    logic resolve;

    assign stall   = is_bcc & needs_flags & ~flags_vld & ~wait_q;
    assign resolve = is_bcc & ~stall;
    assign taken   = resolve & holds;
    assign kill    = resolve & annul & ~holds;

    always_ff @(posedge clk) begin
        if (rst) wait_q <= 1'b0;
        else     wait_q <= stall;
    end
endmodule

// File: rtl/br_decode_unit.sv
module br_decode_unit
    import bdu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [XLEN-1:0]     instr_i,
    input  logic                instr_vld_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [3:0]          flags_i,
    input  logic                flags_vld_i,
    input  logic [XLEN-1:0]     ret_val_i,
    output logic                redirect_o,
    output logic [XLEN-1:0]     target_o,
    output logic                slot_kill_o,
    output logic                stall_o,
    output logic [RADDR_W-1:0]  rs_a_o,
    output logic [RADDR_W-1:0]  rs_b_o
);
    dec_t dec;
    logic holds, needs_flags;
    logic br_stall, br_taken, br_kill;
    logic is_bcc, is_call, is_ret;
    logic [XLEN-1:0] tgt;

    bdu_field_decode u_dec (
        .instr (instr_i),
        .vld   (instr_vld_i & ~rst),
        .dec   (dec)
    );

    bdu_cond_eval u_cond (
        .cond        (dec.cond),
        .flags       (flags_t'(flags_i)),
        .holds       (holds),
        .needs_flags (needs_flags)
    );

    assign is_bcc  = (dec.kind == K_BCC);
    assign is_call = (dec.kind == K_CALL);
    assign is_ret  = (dec.kind == K_RET);

    bdu_slot_ctrl u_slot (
        .clk         (clk),
        .rst         (rst),
        .is_bcc      (is_bcc),
        .needs_flags (needs_flags),
        .flags_vld   (flags_vld_i),
        .holds       (holds),
        .annul       (dec.annul),
        .stall       (br_stall),
        .taken       (br_taken),
        .kill        (br_kill)
    );

    always_comb begin
        unique case (dec.kind)
            K_CALL:  tgt = {dec.imm, 2'b00};
            K_RET:   tgt = ret_val_i;
            K_BCC:   tgt = rel_target(pc_i, dec.off);
            default: tgt = '0;
        endcase
    end

    assign redirect_o  = is_call | is_ret | br_taken;
    assign target_o    = redirect_o ? tgt : '0;
    assign slot_kill_o = br_kill;
    assign stall_o     = br_stall;
    assign rs_a_o      = dec.ra;
    assign rs_b_o      = dec.rb;
endmodule

// File: rtl/br_decode_unit_chk.sv
module br_decode_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr_i,
    input logic        instr_vld_i,
    input logic [31:0] ret_val_i,
    input logic        redirect_o,
    input logic [31:0] target_o,
    input logic        slot_kill_o,
    input logic        stall_o
);
    assert_call_target_R1: assert property (@(posedge clk) disable iff (rst)
        (instr_vld_i && instr_i[31:30] == 2'b01) |->
            (redirect_o && !slot_kill_o && target_o == {instr_i[29:0], 2'b00}));

    assert_kill_only_annulled_R5: assert property (@(posedge clk) disable iff (rst)
        slot_kill_o |-> (instr_i[31:24] == 8'h8A && instr_i[19] && !redirect_o));

    assert_ret_target_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_vld_i && instr_i[31:24] == 8'h8C) |-> (redirect_o && target_o == ret_val_i));

    assert_single_stall_R7: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);

    assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (!redirect_o && !slot_kill_o));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !instr_vld_i |-> (!redirect_o && !slot_kill_o && !stall_o));

    always_comb begin
        if (!redirect_o) begin
            assert_target_zero_R1: assert (target_o == 32'd0);
        end
    end
endmodule

bind br_decode_unit br_decode_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_i     (instr_i),
    .instr_vld_i (instr_vld_i),
    .ret_val_i   (ret_val_i),
    .redirect_o  (redirect_o),
    .target_o    (target_o),
    .slot_kill_o (slot_kill_o),
    .stall_o     (stall_o)
);

// File: tb/br_decode_unit_tb_top.sv
`timescale 1ns/1ps
module br_decode_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        ivld = 1'b0;
    logic [31:0] pc = '0;
    logic [3:0]  flags = '0;
    logic        fvld = 1'b0;
    logic [31:0] retv = 32'h0000_4440;
    logic        redirect, kill, stall;
    logic [31:0] target;
    logic [4:0]  rsa, rsb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    br_decode_unit dut_i (
        .clk(clk), .rst(rst), .instr_i(instr), .instr_vld_i(ivld), .pc_i(pc),
        .flags_i(flags), .flags_vld_i(fvld), .ret_val_i(retv),
        .redirect_o(redirect), .target_o(target), .slot_kill_o(kill),
        .stall_o(stall), .rs_a_o(rsa), .rs_b_o(rsb)
    );

    // kind: 0 branch, 1 call, 2 return, 3 not a transfer
    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  cond;
        logic        an;
        logic [29:0] imm;
        logic [3:0]  fl;
        logic        fv;
        logic        exp_redir;
        logic        exp_kill;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 4'b1000, 1'b1, 30'd5,        4'b0000, 1'b0, 1'b1, 1'b0}, // R8 always
        '{2'd0, 4'b0000, 1'b1, 30'd5,        4'b0000, 1'b0, 1'b0, 1'b1}, // R8 never, annul
        '{2'd0, 4'b0000, 1'b0, 30'd5,        4'b0000, 1'b0, 1'b0, 1'b0}, // R4
        '{2'd0, 4'b0001, 1'b0, 30'h7FFFD,    4'b0100, 1'b1, 1'b1, 1'b0}, // eq, neg offset
        '{2'd0, 4'b1001, 1'b1, 30'd7,        4'b0100, 1'b1, 1'b0, 1'b1}, // ne
        '{2'd0, 4'b0011, 1'b0, 30'd9,        4'b1000, 1'b1, 1'b1, 1'b0}, // lt
        '{2'd0, 4'b1011, 1'b0, 30'd9,        4'b1001, 1'b1, 1'b1, 1'b0}, // ge
        '{2'd0, 4'b0010, 1'b1, 30'd2,        4'b0000, 1'b1, 1'b0, 1'b1}, // le
        '{2'd0, 4'b1010, 1'b1, 30'd2,        4'b0000, 1'b1, 1'b1, 1'b0}, // gt
        '{2'd0, 4'b0100, 1'b0, 30'd3,        4'b0010, 1'b1, 1'b1, 1'b0}, // leu
        '{2'd0, 4'b1100, 1'b0, 30'd3,        4'b0010, 1'b1, 1'b0, 1'b0}, // gtu
        '{2'd0, 4'b0101, 1'b1, 30'd4,        4'b0000, 1'b1, 1'b0, 1'b1}, // cs
        '{2'd0, 4'b1101, 1'b0, 30'd4,        4'b0000, 1'b1, 1'b1, 1'b0}, // cc
        '{2'd0, 4'b0110, 1'b0, 30'd6,        4'b1000, 1'b1, 1'b1, 1'b0}, // neg
        '{2'd0, 4'b1110, 1'b1, 30'd6,        4'b1000, 1'b1, 1'b0, 1'b1}, // pos
        '{2'd0, 4'b0111, 1'b0, 30'd8,        4'b0001, 1'b1, 1'b1, 1'b0}, // vs
        '{2'd0, 4'b1111, 1'b0, 30'd8,        4'b0001, 1'b1, 1'b0, 1'b0}, // vc
        '{2'd1, 4'b0000, 1'b0, 30'h0ABCDEF,  4'b0000, 1'b0, 1'b1, 1'b0}, // call
        '{2'd2, 4'b0000, 1'b0, 30'd0,        4'b0000, 1'b0, 1'b1, 1'b0}, // return
        '{2'd3, 4'b0000, 1'b0, 30'd0,        4'b1111, 1'b1, 1'b0, 1'b0}, // not a transfer
        '{2'd0, 4'b1000, 1'b0, 30'h3FFFF,    4'b0000, 1'b1, 1'b1, 1'b0}, // max forward
        '{2'd0, 4'b1000, 1'b1, 30'h40000,    4'b0000, 1'b1, 1'b1, 1'b0}  // max backward
    };

    function automatic logic [31:0] mk_instr(vec_t v);
        case (v.kind)
            2'd0:    return {8'h8A, v.cond, v.an, v.imm[18:0]};
            2'd1:    return {2'b01, v.imm};
            2'd2:    return {8'h8C, 5'd3, 5'd17, 14'd0};
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [31:0] exp_target(vec_t v, logic [31:0] p);
        if (!v.exp_redir) return 32'd0;
        case (v.kind)
            2'd1:    return {v.imm, 2'b00};
            2'd2:    return retv;
            default: return p + 32'($signed({v.imm[18:0], 2'b00}));
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_bcc(input logic [3:0] c, input logic an, input logic [3:0] f,
                             input logic fv);
        instr = {8'h8A, c, an, 19'd16};
        ivld  = 1'b1;
        flags = f;
        fvld  = fv;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: outputs inactive during reset
        @(negedge clk);
        drive_bcc(4'b0001, 1'b1, 4'b0000, 1'b0);
        #1;
        chk("R10 stall in reset", 32'(stall), 32'd0);
        chk("R10 kill in reset", 32'(kill), 32'd0);
        instr = {2'b01, 30'd9};
        #1;
        chk("R10 redirect in reset", 32'(redirect), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        ivld = 1'b0;
        #1;
        chk("R9 idle redirect", 32'(redirect), 32'd0);

        // table walk: R1..R6, R8, R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pc    = 32'h0010_0000 + 32'(i * 16);
            instr = mk_instr(TBL[i]);
            ivld  = 1'b1;
            flags = TBL[i].fl;
            fvld  = TBL[i].fv;
            #1;
            chk($sformatf("R3 redirect vec %0d", i), 32'(redirect), 32'(TBL[i].exp_redir));
            chk($sformatf("R5 kill vec %0d", i), 32'(kill), 32'(TBL[i].exp_kill));
            chk($sformatf("R2 target vec %0d", i), target, exp_target(TBL[i], pc));
            chk($sformatf("R8 stall vec %0d", i), 32'(stall), 32'd0);
            chk($sformatf("R6 rs_a vec %0d", i), 32'(rsa), (TBL[i].kind == 2'd2) ? 32'd3 : 32'd0);
            chk($sformatf("R6 rs_b vec %0d", i), 32'(rsb), (TBL[i].kind == 2'd2) ? 32'd17 : 32'd0);
        end

        // R9: invalid word with call encoding
        @(negedge clk);
        instr = {2'b01, 30'd44};
        ivld  = 1'b0;
        #1;
        chk("R9 invalid call redirect", 32'(redirect), 32'd0);
        chk("R9 invalid call target", target, 32'd0);

        // R7 + R5: wait, then annul kill on next cycle's flags
        @(negedge clk);
        pc = 32'h0000_2000;
        drive_bcc(4'b0001, 1'b1, 4'b0100, 1'b0);
        #1;
        chk("R7 stall first cycle", 32'(stall), 32'd1);
        chk("R7 no redirect while waiting", 32'(redirect), 32'd0);
        chk("R7 no kill while waiting", 32'(kill), 32'd0);
        @(negedge clk);
        flags = 4'b0000;
        #1;
        chk("R7 stall released", 32'(stall), 32'd0);
        chk("R5 kill after wait", 32'(kill), 32'd1);
        chk("R7 no redirect after wait", 32'(redirect), 32'd0);

        // R7: wait resolving to taken, flags_vld still low
        @(negedge clk);
        drive_bcc(4'b1001, 1'b1, 4'b0100, 1'b0);
        #1;
        chk("R7 stall again", 32'(stall), 32'd1);
        @(negedge clk);
        flags = 4'b0000;
        #1;
        chk("R7 taken after wait", 32'(redirect), 32'd1);
        chk("R7 target after wait", target, 32'h0000_2040);
        chk("R5 no kill when taken", 32'(kill), 32'd0);

        // R10: reset during a wait clears it
        @(negedge clk);
        ivld = 1'b0;
        @(negedge clk);
        drive_bcc(4'b0011, 1'b0, 4'b0000, 1'b0);
        #1;
        chk("R7 stall before reset", 32'(stall), 32'd1);
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk("R10 stall masked by reset", 32'(stall), 32'd0);
        chk("R10 redirect masked by reset", 32'(redirect), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 wait cleared, stall again", 32'(stall), 32'd1);
        chk("R10 no early decision", 32'(redirect), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule